// File: doc/BRIEF.md
# Guest Event Blocking State Tracker

This block keeps the set of event-blocking conditions that apply to a virtualized guest context. It holds interrupt shadowing after a stack-segment load or an interrupt-enable instruction, NMI blocking, virtual-NMI blocking, SMI blocking and the guest's activity state. A single-cycle guest-entry pulse loads all of these at once from an interruptibility-state word, two execution-control bits, and flags that describe the entry. After that, instruction retirement, exceptions, IRET and guest exit update them.

NMI blocking has three lifetimes, and the entry's control bits pick one. In the first it lasts until an IRET. In the second it lasts for the whole guest residency. In the third, real NMIs are not blocked and a separate virtual-NMI flag takes their place. SMI blocking is loaded only when the entry is made from system-management mode; any other entry leaves it as it was. Every register updates on the clock edge that samples its cause, so each output shows the new value one cycle after the pulse.

Top module: `gevt_block_tracker`

## Requirements
- R1: On entry, STI blocking (`sti_blk`) is loaded from bit 0 of `intr_state`.
- R2: On entry, MOV-SS blocking (`movss_blk`) is loaded from bit 1 of `intr_state`.
- R3: Both shadow flags stay set on idle cycles. A single `retire` or `exc` pulse clears both of them.
- R4: On an entry with `ctl_vnmi`=0, `nmi_blk` equals bit 3 of `intr_state` and `vnmi_blk` is 0.
- R5: When `ctl_vnmi`=0 and `ctl_nmi_exit`=0, NMI blocking survives retirements and exceptions. An `iret` pulse clears it, whether or not that IRET faults.
- R6: When `ctl_vnmi`=0 and `ctl_nmi_exit`=1, `iret` has no effect on NMI blocking. The blocking holds until guest exit.
- R7: On an entry with `ctl_vnmi`=1, real NMI blocking is 0, and `vnmi_blk` is set if bit 3 of `intr_state` is 1 or `inject_nmi` is 1. A later `iret` clears `vnmi_blk`.
- R8: An entry with `in_smm`=1 loads `smi_blk` from bit 2 of `intr_state`. An entry with `in_smm`=0, and also a guest exit, leaves `smi_blk` unchanged.
- R9: `act_state` uses the encoding 0 active, 1 halt, 2 shutdown, 3 wait-for-SIPI. A vectoring entry sets it to 0. A non-vectoring entry loads it from `act_req`.
- R10: While `act_state` is 3 (wait-for-SIPI), `nmi_blk` reads 1 whatever bit 3 held.
- R11: An `exit_pulse` clears `sti_blk`, `movss_blk`, `nmi_blk`, `vnmi_blk` and `in_guest`, and returns `act_state` to 0, on the next edge. `in_guest` is set by entry.
- R12: An entry pulse takes priority over an exit, retire, exception or IRET pulse in the same cycle. The loaded values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| entry_pulse | input | 1 | Guest entry; loads all state |
| intr_state | input | INTR_W | Interruptibility-state word (bits 0..3 used) |
| ctl_vnmi | input | 1 | Virtual-NMI execution control |
| ctl_nmi_exit | input | 1 | NMI-exiting execution control |
| in_smm | input | 1 | Entry made from system-management mode |
| vectoring | input | 1 | Entry delivers an event |
| inject_nmi | input | 1 | Entry injects an NMI |
| act_req | input | 2 | Requested activity state |
| retire | input | 1 | One guest instruction retired |
| exc | input | 1 | Guest took an exception |
| iret | input | 1 | Guest executed IRET |
| exit_pulse | input | 1 | Guest exit |
| sti_blk | output | 1 | Blocking by STI |
| movss_blk | output | 1 | Blocking by MOV SS |
| nmi_blk | output | 1 | NMIs blocked |
| vnmi_blk | output | 1 | Virtual-NMI blocking |
| smi_blk | output | 1 | SMIs blocked |
| act_state | output | 2 | Current activity state |
| in_guest | output | 1 | Guest context resident |

## Verification
The properties assume that every control input is a single-cycle pulse sampled at a rising edge, and that `act_req` and the control bits are stable whenever `entry_pulse` is high. The retire/exception clearing check counts only cycles without an entry, because an entry wins under R12. The bench drives every input on the falling edge, raises each pulse for exactly one cycle, and returns all pulses to zero before the next edge. It samples outputs on the falling edge after the edge that acts. Scenarios that depend on an NMI lifetime are confirmed from the ports by the bench rather than by properties, since no port shows the lifetime chosen at entry.

// File: rtl/gevt_pkg.sv
// Package: shared encodings for the guest event blocking tracker.
// Assumes the interruptibility word carries its flags at fixed low bit positions.
package gevt_pkg;
    localparam int BIT_STI   = 0;
    localparam int BIT_MOVSS = 1;
    localparam int BIT_SMI   = 2;
    localparam int BIT_NMI   = 3;
    localparam int MIN_INTR_W = 4;
    localparam int NUM_SHADOW = 2;

    typedef enum logic [1:0] {
        ACT_RUN       = 2'd0,
        ACT_HALT      = 2'd1,
        ACT_SHUTDOWN  = 2'd2,
        ACT_SIPI_WAIT = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        NMI_UNTIL_IRET = 2'd0,
        NMI_RESIDENT   = 2'd1,
        NMI_VIRTUAL    = 2'd2
    } nmi_mode_e;

    typedef struct packed {
        nmi_mode_e mode;
        logic      hard;
        logic      virt;
        logic      smi_load;
        logic      smi_val;
        act_e      act;
    } entry_load_t;
endpackage

// File: rtl/gevt_entry_decode.sv
// Module: gevt_entry_decode
// Turns the entry-time inputs into the values loaded into the tracker registers.
// Purely combinational. Assumes the inputs are valid in the cycle the entry pulse is high.
module gevt_entry_decode
    import gevt_pkg::*;
#(
    parameter int INTR_W = 4
) (
    input  logic [INTR_W-1:0] intr_state,
    input  logic              ctl_vnmi,
    input  logic              ctl_nmi_exit,
    input  logic              in_smm,
    input  logic              vectoring,
    input  logic              inject_nmi,
    input  logic [1:0]        act_req,
    output entry_load_t       load
);
    localparam int USED_W = MIN_INTR_W;

    logic [USED_W-1:0] low_bits;
    assign low_bits = intr_state[USED_W-1:0];

    // Select the NMI lifetime and the initial blocking values from the controls.
    always_comb begin
        if (ctl_vnmi) begin
            load.mode = NMI_VIRTUAL;
        end else if (ctl_nmi_exit) begin
            load.mode = NMI_RESIDENT;
        end else begin
            load.mode = NMI_UNTIL_IRET;
        end
        load.hard     = !ctl_vnmi && low_bits[BIT_NMI];
        load.virt     = ctl_vnmi && (low_bits[BIT_NMI] || inject_nmi);
        load.smi_load = in_smm;
        load.smi_val  = low_bits[BIT_SMI];
        load.act      = vectoring ? ACT_RUN : act_e'(act_req);
    end

    if (INTR_W > USED_W) begin : g_upper
        logic upper_unused;
        assign upper_unused = ^intr_state[INTR_W-1:USED_W];
    end
endmodule

// File: rtl/gevt_shadow_flag.sv
// Module: gevt_shadow_flag
// A one-instruction shadow flag. It is loaded on entry and cleared by the first
// retirement, exception or exit. Assumes the load has priority over the clear.
module gevt_shadow_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic load_val,
    input  logic clr,
    output logic q
);
    // Hold the shadow until something ends it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (load_en) begin
            q <= load_val;
        end else if (clr) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/gevt_nmi_track.sv
// Module: gevt_nmi_track
// Holds real and virtual NMI blocking together with the lifetime chosen at entry.
// Assumes load_en dominates; exit clears both flags; IRET acts per the lifetime.
module gevt_nmi_track
    import gevt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_en,
    input  nmi_mode_e load_mode,
    input  logic      load_hard,
    input  logic      load_virt,
    input  logic      iret,
    input  logic      exit_clr,
    output logic      hard_blk,
    output logic      virt_blk
);
    nmi_mode_e mode_q;

    // Remember which lifetime governs the current residency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= NMI_UNTIL_IRET;
        end else if (load_en) begin
            mode_q <= load_mode;
        end
    end

    // Real NMI blocking: cleared by IRET only in the until-IRET lifetime.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hard_blk <= 1'b0;
        end else if (load_en) begin
            hard_blk <= load_hard;
        end else if (exit_clr) begin
            hard_blk <= 1'b0;
        end else if (iret && mode_q == NMI_UNTIL_IRET) begin
            hard_blk <= 1'b0;
        end
    end

    // Virtual NMI blocking: cleared by IRET in the virtual lifetime.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            virt_blk <= 1'b0;
        end else if (load_en) begin
            virt_blk <= load_virt;
        end else if (exit_clr) begin
            virt_blk <= 1'b0;
        end else if (iret && mode_q == NMI_VIRTUAL) begin
            virt_blk <= 1'b0;
        end
    end
endmodule

// File: rtl/gevt_block_tracker.sv
// Module: gevt_block_tracker (top)
// Tracks the event blocking state of a guest context between entry and exit.
// Assumes single-cycle pulses and an entry that dominates every other event in its cycle.
module gevt_block_tracker
    import gevt_pkg::*;
#(
    parameter int INTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_pulse,
    input  logic [INTR_W-1:0] intr_state,
    input  logic              ctl_vnmi,
    input  logic              ctl_nmi_exit,
    input  logic              in_smm,
    input  logic              vectoring,
    input  logic              inject_nmi,
    input  logic [1:0]        act_req,
    input  logic              retire,
    input  logic              exc,
    input  logic              iret,
    input  logic              exit_pulse,
    output logic              sti_blk,
    output logic              movss_blk,
    output logic              nmi_blk,
    output logic              vnmi_blk,
    output logic              smi_blk,
    output logic [1:0]        act_state,
    output logic              in_guest
);
    entry_load_t         load;
    logic [NUM_SHADOW-1:0] shadow_q;
    logic                hard_blk;
    logic                shadow_clr;
    act_e                act_q;
    logic                smi_q;
    logic                guest_q;

    gevt_entry_decode #(.INTR_W(INTR_W)) u_dec (
        .intr_state   (intr_state),
        .ctl_vnmi     (ctl_vnmi),
        .ctl_nmi_exit (ctl_nmi_exit),
        .in_smm       (in_smm),
        .vectoring    (vectoring),
        .inject_nmi   (inject_nmi),
        .act_req      (act_req),
        .load         (load)
    );

    assign shadow_clr = retire || exc || exit_pulse;

    for (genvar i = 0; i < NUM_SHADOW; i++) begin : g_shadow
        localparam int BITPOS = (i == 0) ? BIT_STI : BIT_MOVSS;
        gevt_shadow_flag u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (entry_pulse),
            .load_val (intr_state[BITPOS]),
            .clr      (shadow_clr),
            .q        (shadow_q[i])
        );
    end

    gevt_nmi_track u_nmi (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (entry_pulse),
        .load_mode (load.mode),
        .load_hard (load.hard),
        .load_virt (load.virt),
        .iret      (iret),
        .exit_clr  (exit_pulse),
        .hard_blk  (hard_blk),
        .virt_blk  (vnmi_blk)
    );

    // Activity state: loaded on entry, back to active on exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= ACT_RUN;
        end else if (entry_pulse) begin
            act_q <= load.act;
        end else if (exit_pulse) begin
            act_q <= ACT_RUN;
        end
    end

    // SMI blocking: only an entry from SMM replaces it; it outlives the guest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_q <= 1'b0;
        end else if (entry_pulse && load.smi_load) begin
            smi_q <= load.smi_val;
        end
    end

    // Residency flag: set by entry, cleared by exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guest_q <= 1'b0;
        end else if (entry_pulse) begin
            guest_q <= 1'b1;
        end else if (exit_pulse) begin
            guest_q <= 1'b0;
        end
    end

    assign sti_blk   = shadow_q[0];
    assign movss_blk = shadow_q[1];
    assign nmi_blk   = hard_blk || (act_q == ACT_SIPI_WAIT);
    assign smi_blk   = smi_q;
    assign act_state = act_q;
    assign in_guest  = guest_q;
endmodule

// File: rtl/gevt_block_tracker_chk.sv
// Module: gevt_block_tracker_chk
// Port-level properties of the tracker, bound into every instance of the top.
module gevt_block_tracker_chk #(
    parameter int INTR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              entry_pulse,
    input logic [INTR_W-1:0] intr_state,
    input logic              ctl_vnmi,
    input logic              ctl_nmi_exit,
    input logic              in_smm,
    input logic              vectoring,
    input logic              inject_nmi,
    input logic [1:0]        act_req,
    input logic              retire,
    input logic              exc,
    input logic              iret,
    input logic              exit_pulse,
    input logic              sti_blk,
    input logic              movss_blk,
    input logic              nmi_blk,
    input logic              vnmi_blk,
    input logic              smi_blk,
    input logic [1:0]        act_state,
    input logic              in_guest
);
    // R1
    sti_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |=> sti_blk == $past(intr_state[0]));
    // R2
    movss_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |=> movss_blk == $past(intr_state[1]));
    // R3
    shadow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!entry_pulse && (retire || exc)) |=> (!sti_blk && !movss_blk));
    // R4
    nmi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_pulse && !ctl_vnmi && intr_state[3]) |=> (nmi_blk && !vnmi_blk));
    // R7
    vnmi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_pulse && ctl_vnmi) |=> vnmi_blk == ($past(intr_state[3]) || $past(inject_nmi)));
    // R7
    vnmi_no_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_pulse && ctl_vnmi && (vectoring || act_req != 2'd3)) |=> !nmi_blk);
    // R8
    smi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_pulse && !in_smm) |=> $stable(smi_blk));
    // R8
    smi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_pulse && in_smm) |=> smi_blk == $past(intr_state[2]));
    // R9
    act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |=> act_state == ($past(vectoring) ? 2'd0 : $past(act_req)));
    // R10
    sipi_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_pulse && !vectoring && act_req == 2'd3) |=> nmi_blk);
    // R11
    exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_pulse && !entry_pulse) |=> (!sti_blk && !movss_blk && !nmi_blk && !vnmi_blk
                                          && !in_guest && act_state == 2'd0));
    // R12
    entry_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |=> in_guest);
endmodule

bind gevt_block_tracker gevt_block_tracker_chk #(.INTR_W(INTR_W)) u_chk (.*);

// File: tb/sim_gevt_block_tracker.sv
module sim_gevt_block_tracker;
    localparam int INTR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              entry_pulse = 1'b0;
    logic [INTR_W-1:0] intr_state = '0;
    logic              ctl_vnmi = 1'b0;
    logic              ctl_nmi_exit = 1'b0;
    logic              in_smm = 1'b0;
    logic              vectoring = 1'b0;
    logic              inject_nmi = 1'b0;
    logic [1:0]        act_req = 2'd0;
    logic              retire = 1'b0;
    logic              exc = 1'b0;
    logic              iret = 1'b0;
    logic              exit_pulse = 1'b0;
    logic              sti_blk, movss_blk, nmi_blk, vnmi_blk, smi_blk, in_guest;
    logic [1:0]        act_state;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gevt_block_tracker #(.INTR_W(INTR_W)) u0 (
        .clk, .rst_n, .entry_pulse, .intr_state, .ctl_vnmi, .ctl_nmi_exit,
        .in_smm, .vectoring, .inject_nmi, .act_req, .retire, .exc, .iret,
        .exit_pulse, .sti_blk, .movss_blk, .nmi_blk, .vnmi_blk, .smi_blk,
        .act_state, .in_guest
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One entry pulse; outputs are valid at the falling edge after it.
    task automatic enter(input logic [3:0] word, input logic vn, input logic ne,
                         input logic smm, input logic vec, input logic inj,
                         input logic [1:0] req);
        @(negedge clk);
        intr_state = word; ctl_vnmi = vn; ctl_nmi_exit = ne; in_smm = smm;
        vectoring = vec; inject_nmi = inj; act_req = req; entry_pulse = 1'b1;
        @(negedge clk);
        entry_pulse = 1'b0; intr_state = '0; inject_nmi = 1'b0;
    endtask

    task automatic pulse(input bit r, input bit e, input bit i, input bit x);
        @(negedge clk);
        retire = r; exc = e; iret = i; exit_pulse = x;
        @(negedge clk);
        retire = 1'b0; exc = 1'b0; iret = 1'b0; exit_pulse = 1'b0;
    endtask

    task automatic t_reset();
        chk("reset sti", sti_blk, 0);
        chk("reset movss", movss_blk, 0);
        chk("reset nmi", nmi_blk, 0);
        chk("reset smi", smi_blk, 0);
        chk("reset act", act_state, 0);
        chk("reset guest", in_guest, 0);
    endtask

    task automatic t_shadow();
        enter(4'b0011, 0, 0, 0, 0, 0, 2'd0);
        chk("R1 sti load", sti_blk, 1);
        chk("R2 movss load", movss_blk, 1);
        @(negedge clk);
        chk("R3 sti held idle", sti_blk, 1);
        pulse(1, 0, 0, 0);
        chk("R3 sti cleared by retire", sti_blk, 0);
        chk("R3 movss cleared by retire", movss_blk, 0);
        enter(4'b0010, 0, 0, 0, 0, 0, 2'd0);
        chk("R1 sti load zero", sti_blk, 0);
        pulse(0, 1, 0, 0);
        chk("R3 movss cleared by exception", movss_blk, 0);
        pulse(0, 0, 0, 1);
    endtask

    task automatic t_nmi_iret();
        enter(4'b1000, 0, 0, 0, 0, 0, 2'd0);
        chk("R4 nmi load", nmi_blk, 1);
        chk("R4 vnmi zero", vnmi_blk, 0);
        pulse(1, 1, 0, 0);
        chk("R5 nmi survives retire", nmi_blk, 1);
        pulse(0, 0, 1, 0);
        chk("R5 iret clears nmi", nmi_blk, 0);
        pulse(0, 0, 0, 1);
    endtask

    task automatic t_nmi_resident();
        enter(4'b1000, 0, 1, 0, 0, 0, 2'd0);
        chk("R4 nmi load resident", nmi_blk, 1);
        pulse(0, 0, 1, 0);
        chk("R6 iret ignored", nmi_blk, 1);
        pulse(0, 0, 0, 1);
        chk("R11 exit clears nmi", nmi_blk, 0);
        chk("R11 exit clears guest", in_guest, 0);
    endtask

    task automatic t_vnmi();
        enter(4'b1000, 1, 0, 0, 0, 0, 2'd0);
        chk("R7 no real nmi", nmi_blk, 0);
        chk("R7 vnmi from bit3", vnmi_blk, 1);
        pulse(0, 0, 1, 0);
        chk("R7 iret clears vnmi", vnmi_blk, 0);
        enter(4'b0000, 1, 0, 0, 0, 1, 2'd0);
        chk("R7 vnmi from injection", vnmi_blk, 1);
        pulse(0, 0, 0, 1);
        chk("R11 exit clears vnmi", vnmi_blk, 0);
        enter(4'b0000, 1, 0, 0, 0, 0, 2'd0);
        chk("R7 vnmi clear", vnmi_blk, 0);
        pulse(0, 0, 0, 1);
    endtask

    task automatic t_smi();
        enter(4'b0100, 0, 0, 1, 0, 0, 2'd0);
        chk("R8 smi load in smm", smi_blk, 1);
        enter(4'b0000, 0, 0, 0, 0, 0, 2'd0);
        chk("R8 smi held outside smm", smi_blk, 1);
        pulse(0, 0, 0, 1);
        chk("R8 smi held over exit", smi_blk, 1);
        enter(4'b0000, 0, 0, 1, 0, 0, 2'd0);
        chk("R8 smi reload zero", smi_blk, 0);
        pulse(0, 0, 0, 1);
    endtask

    task automatic t_activity();
        enter(4'b0000, 0, 0, 0, 0, 0, 2'd1);
        chk("R9 halt loaded", act_state, 1);
        enter(4'b0000, 0, 0, 0, 1, 0, 2'd2);
        chk("R9 vectoring forces active", act_state, 0);
        enter(4'b0000, 0, 0, 0, 0, 0, 2'd2);
        chk("R9 shutdown loaded", act_state, 2);
        enter(4'b0000, 0, 0, 0, 0, 0, 2'd3);
        chk("R9 sipi loaded", act_state, 3);
        chk("R10 sipi blocks nmi", nmi_blk, 1);
        pulse(0, 0, 0, 1);
        chk("R11 exit to active", act_state, 0);
        chk("R11 nmi clear after exit", nmi_blk, 0);
    endtask

    task automatic t_priority();
        @(negedge clk);
        intr_state = 4'b1011; entry_pulse = 1'b1; exit_pulse = 1'b1; retire = 1'b1;
        ctl_vnmi = 1'b0; ctl_nmi_exit = 1'b0; vectoring = 1'b0; act_req = 2'd1;
        @(negedge clk);
        entry_pulse = 1'b0; exit_pulse = 1'b0; retire = 1'b0; intr_state = '0;
        chk("R12 guest set despite exit", in_guest, 1);
        chk("R12 sti despite retire", sti_blk, 1);
        chk("R12 nmi despite exit", nmi_blk, 1);
        chk("R12 act despite exit", act_state, 1);
        pulse(0, 0, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shadow();
        t_nmi_iret();
        t_nmi_resident();
        t_vnmi();
        t_smi();
        t_activity();
        t_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule